// File: doc/BRIEF.md
# Completion Packetizer With Payload Boundaries

This block turns the read data of one request into a sequence of outbound completion packets. A request gives a start byte address and a total byte count. The data then arrives as a stream of 8-byte beats. The block counts the valid bytes of each beat and closes a packet in two cases: when the running byte address lands on a naturally aligned boundary of the active payload size, or when the request has no bytes left. For every closed packet it pushes a descriptor into a small completion queue. The descriptor holds the packet's start address, its byte count and the bytes of the request still outstanding after it.

The payload size comes from a two-bit maximum-payload selector that picks 128, 256 or 512 bytes. A separate override bit forces 128-byte packets whatever the selector says. Both settings are sampled when a request is accepted and hold for that whole request. The accepted beats are echoed on a registered data output, and the last beat of each packet is marked there. A one-cycle done strobe marks every push into the queue.

Top module: `completion_packetizer`

## Requirements
- R1: After reset, req_ready is 1 and in_ready, cq_valid, pkt_done, dout_valid and dout_eop are all 0. A reset in the middle of a request abandons it, and the block returns to that idle state.
- R2: With cfg_force128 at 0, cfg_mps selects the payload size: 2'b01 gives 256 bytes, 2'b10 gives 512 bytes, and 2'b00 or 2'b11 gives 128 bytes. A packet closes when the address after its last byte is a multiple of that size.
- R3: With cfg_force128 at 1, the payload size is 128 bytes whatever cfg_mps holds.
- R4: When the start address is not a multiple of the payload size, the first packet carries only the bytes up to the next boundary.
- R5: When the request ends before a boundary, the final packet carries the remaining bytes. After it the outstanding count is 0.
- R6: Each queue entry gives cq_addr (the packet's first byte address), cq_len (its byte count, never 0) and cq_remain (the request bytes still due after this packet). Entries leave in the order they were formed.
- R7: A beat carries min(8 - addr mod 8, remaining) bytes. Each accepted beat appears on dout_data one cycle later with dout_valid, and dout_eop is 1 on the last beat of each packet.
- R8: pkt_done is high for exactly one cycle per packet, in the cycle after the beat that closed the packet was accepted.
- R9: Changes to cfg_mps or cfg_force128 while a request is in progress do not affect that request's packet sizes.
- R10: req_ready is 0 while a request is in progress. in_ready is 0 when no request is active or when the completion queue is full, and the queue never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_addr | input | ADDR_W | First byte address of the request |
| req_len | input | LEN_W | Total byte count of the request, nonzero |
| cfg_mps | input | 2 | Max-payload selector |
| cfg_force128 | input | 1 | Force 128-byte packets |
| in_valid | input | 1 | Data beat offered |
| in_ready | output | 1 | Data beat accepted on valid |
| in_data | input | 64 | Data beat, 8 bytes |
| dout_valid | output | 1 | Registered echo of an accepted beat |
| dout_data | output | 64 | Echoed beat data |
| dout_eop | output | 1 | Echoed beat is the last of its packet |
| cq_valid | output | 1 | Completion queue holds an entry |
| cq_ready | input | 1 | Pop the head entry |
| cq_addr | output | ADDR_W | Head entry start address |
| cq_len | output | LEN_W | Head entry byte count |
| cq_remain | output | LEN_W | Request bytes outstanding after the head entry |
| pkt_done | output | 1 | One-cycle strobe per packet pushed |

## Verification
On every cycle, the assertions check that no pushed packet is longer than the latched payload size or empty. They also check that the latched size stays fixed while a request is active, that the outstanding byte count falls with every accepted beat, that no beat is accepted while idle or while the queue is full, and that the end-of-packet mark only rides on a valid beat. Only the bench's scenarios can show that the cuts land on the correct aligned addresses for each size setting and for the override, and that unaligned starts and short tails produce the right lengths. The same holds for the descriptor order across a stalled queue, the data echo order, and a mid-request reset.

// File: rtl/cpk_pkg.sv
package cpk_pkg;

  localparam int unsigned BEAT_BYTES = 8;
  localparam int unsigned BEAT_W     = BEAT_BYTES * 8;

  typedef enum logic [1:0] {
    MPS_128 = 2'b00,
    MPS_256 = 2'b01,
    MPS_512 = 2'b10,
    MPS_ALT = 2'b11
  } mps_sel_e;

  // log2 of the payload size picked by the selector and override
  function automatic logic [3:0] cpk_size_lg(input logic [1:0] mps, input logic frc);
    logic [3:0] lg;
    if (frc) begin
      lg = 4'd7;
    end else begin
      case (mps_sel_e'(mps))
        MPS_256: lg = 4'd8;
        MPS_512: lg = 4'd9;
        default: lg = 4'd7;
      endcase
    end
    return lg;
  endfunction

endpackage

// File: rtl/cpk_beat_acct.sv
module cpk_beat_acct
  import cpk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic [3:0]        size_lg,
  output logic [3:0]        beat_bytes,
  output logic [ADDR_W-1:0] next_addr,
  output logic [LEN_W-1:0]  next_remain,
  output logic              close
);

  localparam int OFF_W = $clog2(BEAT_BYTES);

  logic [3:0]        room;
  logic [ADDR_W-1:0] size_mask;
  logic              at_boundary;

  always_comb begin
    room = 4'(BEAT_BYTES) - 4'(cur_addr[OFF_W-1:0]);
    if (remain < LEN_W'(room)) begin
      beat_bytes = remain[3:0];
    end else begin
      beat_bytes = room;
    end
    next_addr   = cur_addr + ADDR_W'(beat_bytes);
    next_remain = remain - LEN_W'(beat_bytes);
    size_mask   = (ADDR_W'(1) << size_lg) - ADDR_W'(1);
    at_boundary = (next_addr & size_mask) == '0;
    close       = at_boundary || (next_remain == '0);
  end

endmodule

// File: rtl/cpk_cut_ctrl.sv
module cpk_cut_ctrl
  import cpk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        cfg_mps,
  input  logic              cfg_force128,
  input  logic              beat_fire,
  output logic              busy,
  output logic              close_now,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr,
  output logic [LEN_W-1:0]  push_len,
  output logic [LEN_W-1:0]  push_remain
);

  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [ADDR_W-1:0] pkt_start;
  logic [LEN_W-1:0]  pkt_bytes;
  logic [3:0]        size_lg;

  logic [3:0]        nb;
  logic [ADDR_W-1:0] nxt_addr;
  logic [LEN_W-1:0]  nxt_rem;
  logic              cut;

  cpk_beat_acct #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) acct_i (
    .cur_addr   (cur_addr),
    .remain     (remain),
    .size_lg    (size_lg),
    .beat_bytes (nb),
    .next_addr  (nxt_addr),
    .next_remain(nxt_rem),
    .close      (cut)
  );

  assign req_ready   = !busy;
  assign close_now   = cut;
  assign push        = beat_fire && cut;
  assign push_addr   = pkt_start;
  assign push_len    = pkt_bytes + LEN_W'(nb);
  assign push_remain = nxt_rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cur_addr  <= '0;
      remain    <= '0;
      pkt_start <= '0;
      pkt_bytes <= '0;
      size_lg   <= 4'd7;
    end else if (!busy) begin
      if (req_valid) begin
        busy      <= 1'b1;
        cur_addr  <= req_addr;
        remain    <= req_len;
        pkt_start <= req_addr;
        pkt_bytes <= '0;
        size_lg   <= cpk_size_lg(cfg_mps, cfg_force128);
      end
    end else if (beat_fire) begin
      cur_addr <= nxt_addr;
      remain   <= nxt_rem;
      if (cut) begin
        pkt_start <= nxt_addr;
        pkt_bytes <= '0;
      end else begin
        pkt_bytes <= pkt_bytes + LEN_W'(nb);
      end
      if (nxt_rem == '0) begin
        busy <= 1'b0;
      end
    end
  end

  logic [LEN_W:0] size_bytes;
  assign size_bytes = (LEN_W+1)'(1) << size_lg;

  AST_PKT_WITHIN_SIZE: assert property (@(posedge clk) disable iff (rst)
    push |-> ({1'b0, push_len} <= size_bytes)); // R2

  AST_PKT_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_len != '0)); // R6

  AST_REQ_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (req_len != '0)); // R5

  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(size_lg)); // R9

  AST_REMAIN_FALLS: assert property (@(posedge clk) disable iff (rst)
    (beat_fire && busy) |=> (remain < $past(remain))); // R7

endmodule

// File: rtl/cpk_desc_fifo.sv
module cpk_desc_fifo #(
  parameter int W     = 58,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;
  logic          do_pop;

  assign not_empty = count != '0;
  assign full      = count == CW'(DEPTH);
  assign do_pop    = pop && not_empty;
  assign dout      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      end
      if (do_pop) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
      case ({push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH))); // R10

endmodule

// File: rtl/completion_packetizer.sv
module completion_packetizer
  import cpk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 13,
  parameter int CQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        cfg_mps,
  input  logic              cfg_force128,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_data,
  output logic              dout_valid,
  output logic [63:0]       dout_data,
  output logic              dout_eop,
  output logic              cq_valid,
  input  logic              cq_ready,
  output logic [ADDR_W-1:0] cq_addr,
  output logic [LEN_W-1:0]  cq_len,
  output logic [LEN_W-1:0]  cq_remain,
  output logic              pkt_done
);

  localparam int DESC_W = ADDR_W + 2 * LEN_W;

  logic              busy;
  logic              close_now;
  logic              push;
  logic              beat_fire;
  logic              q_full;
  logic [ADDR_W-1:0] push_addr;
  logic [LEN_W-1:0]  push_len;
  logic [LEN_W-1:0]  push_remain;
  logic [DESC_W-1:0] q_head;

  assign in_ready  = busy && !q_full;
  assign beat_fire = in_valid && in_ready;

  cpk_cut_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) cut_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .cfg_mps     (cfg_mps),
    .cfg_force128(cfg_force128),
    .beat_fire   (beat_fire),
    .busy        (busy),
    .close_now   (close_now),
    .push        (push),
    .push_addr   (push_addr),
    .push_len    (push_len),
    .push_remain (push_remain)
  );

  cpk_desc_fifo #(.W(DESC_W), .DEPTH(CQ_DEPTH)) cq_i (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .din      ({push_addr, push_len, push_remain}),
    .pop      (cq_ready),
    .dout     (q_head),
    .not_empty(cq_valid),
    .full     (q_full)
  );

  assign {cq_addr, cq_len, cq_remain} = q_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
      dout_data  <= '0;
      dout_eop   <= 1'b0;
      pkt_done   <= 1'b0;
    end else begin
      dout_valid <= beat_fire;
      dout_data  <= in_data;
      dout_eop   <= beat_fire && close_now;
      pkt_done   <= push;
    end
  end

  AST_NO_BEAT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !req_ready); // R10

  AST_EOP_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
    dout_eop |-> dout_valid); // R7

  AST_DONE_MATCHES_EOP: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> dout_eop); // R8

endmodule

// File: tb/completion_packetizer_tb.sv
module completion_packetizer_tb_top;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 13;

  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] len;
    logic [1:0]  mps;
    logic        frc;
    logic [7:0]  npk;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 16'd512,  2'b00, 1'b0, 8'd4},  // R2 128
    '{16'h0000, 16'd512,  2'b01, 1'b0, 8'd2},  // R2 256
    '{16'h0000, 16'd512,  2'b10, 1'b0, 8'd1},  // R2 512
    '{16'h0000, 16'd512,  2'b10, 1'b1, 8'd4},  // R3 override
    '{16'h00F0, 16'd300,  2'b01, 1'b0, 8'd3},  // R4 R5 16+256+28
    '{16'h0104, 16'd20,   2'b00, 1'b0, 8'd1},  // R5 R7 short unaligned
    '{16'h007C, 16'd10,   2'b00, 1'b0, 8'd2},  // R4 R7 4+6
    '{16'h0000, 16'd256,  2'b11, 1'b0, 8'd2},  // R2 selector 11
    '{16'h01F8, 16'd1040, 2'b10, 1'b0, 8'd4}   // R4 R5 8+512+512+8
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [1:0]        cfg_mps = 2'b00;
  logic              cfg_force128 = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [63:0]       in_data = '0;
  logic              dout_valid;
  logic [63:0]       dout_data;
  logic              dout_eop;
  logic              cq_valid;
  logic              cq_ready = 1'b1;
  logic [ADDR_W-1:0] cq_addr;
  logic [LEN_W-1:0]  cq_len;
  logic [LEN_W-1:0]  cq_remain;
  logic              pkt_done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  completion_packetizer dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .cfg_mps(cfg_mps), .cfg_force128(cfg_force128),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .dout_valid(dout_valid), .dout_data(dout_data), .dout_eop(dout_eop),
    .cq_valid(cq_valid), .cq_ready(cq_ready),
    .cq_addr(cq_addr), .cq_len(cq_len), .cq_remain(cq_remain),
    .pkt_done(pkt_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int size_of(input logic [1:0] mps, input logic frc);
    if (frc) return 128;
    if (mps == 2'b01) return 256;
    if (mps == 2'b10) return 512;
    return 128;
  endfunction

  task automatic run_req(input int addr, input int len, input logic [1:0] mps,
                         input logic frc, input int npk, input bit do_alt,
                         input logic [1:0] alt_mps, input logic alt_frc,
                         input int hold, input string tag);
    int ps, m_addr, m_rem, nbeats, sent, got, dn, eo, rx, cyc, exp_len, off;
    bit stall;
    ps = size_of(mps, frc);
    m_addr = addr; m_rem = len;
    nbeats = ((addr % 8) + len + 7) / 8;
    sent = 0; got = 0; dn = 0; eo = 0; rx = 0; cyc = 0; stall = 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", {tag, " idle ready"}, req_ready, 1);
    req_valid = 1'b1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len);
    cfg_mps = mps; cfg_force128 = frc;
    @(negedge clk);
    req_valid = 1'b0;
    if (do_alt) begin
      cfg_mps = alt_mps; cfg_force128 = alt_frc;
    end
    chk(req_ready == 1'b0, "R10", {tag, " busy not ready"}, req_ready, 0);
    while (cyc < 4000) begin
      cq_ready = (cyc >= hold);
      in_valid = (sent < nbeats);
      in_data  = 64'(sent);
      #1;
      if (pkt_done) dn++;
      if (dout_eop) eo++;
      if (dout_valid) begin
        chk(dout_data == 64'(rx), "R7", {tag, " echo order"}, dout_data, rx);
        rx++;
      end
      if (cq_valid && cq_ready) begin
        off = m_addr % ps;
        exp_len = (m_rem < ps - off) ? m_rem : ps - off;
        chk(cq_addr == ADDR_W'(m_addr), "R6", {tag, " pkt addr"}, cq_addr, m_addr);
        chk(cq_len == LEN_W'(exp_len), "R2", {tag, " pkt len"}, cq_len, exp_len);
        chk(cq_remain == LEN_W'(m_rem - exp_len), "R6", {tag, " pkt remain"},
            cq_remain, m_rem - exp_len);
        m_addr += exp_len; m_rem -= exp_len; got++;
      end
      if (in_valid && !in_ready) stall = 1;
      if (in_valid && in_ready) sent++;
      if (got >= npk && sent >= nbeats) break;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    cq_ready = 1'b1;
    @(negedge clk);
    if (pkt_done) dn++;
    if (dout_eop) eo++;
    chk(got == npk, "R6", {tag, " packet count"}, got, npk);
    chk(m_rem == 0, "R5", {tag, " bytes left"}, m_rem, 0);
    chk(dn == npk, "R8", {tag, " done pulses"}, dn, npk);
    chk(eo == npk, "R7", {tag, " eop marks"}, eo, npk);
    chk(cq_valid == 1'b0, "R6", {tag, " queue drained"}, cq_valid, 0);
    if (hold > 0) chk(stall == 1'b1, "R10", {tag, " full queue stalls"}, stall, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(in_ready == 1'b0, "R1", "in_ready", in_ready, 0);
    chk(cq_valid == 1'b0, "R1", "cq_valid", cq_valid, 0);
    chk(pkt_done == 1'b0, "R1", "pkt_done", pkt_done, 0);
    chk(dout_valid == 1'b0, "R1", "dout_valid", dout_valid, 0);
    chk(dout_eop == 1'b0, "R1", "dout_eop", dout_eop, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_req(int'(VECS[i].addr), int'(VECS[i].len), VECS[i].mps, VECS[i].frc,
              int'(VECS[i].npk), 1'b0, 2'b00, 1'b0, 0, $sformatf("vec%0d", i));
    end

    // R9 mid-request configuration changes are ignored
    run_req(0, 512, 2'b00, 1'b0, 4, 1'b1, 2'b10, 1'b0, 0, "r9_grow");
    run_req(0, 512, 2'b10, 1'b0, 1, 1'b1, 2'b00, 1'b1, 0, "r9_force");

    // R10 queue full back-pressure, order kept across the stall
    run_req(0, 768, 2'b00, 1'b1, 6, 1'b0, 2'b00, 1'b0, 120, "r10_stall");

    // R1 reset in the middle of a request
    @(negedge clk);
    req_valid = 1'b1; req_addr = '0; req_len = LEN_W'(256);
    cfg_mps = 2'b01; cfg_force128 = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after mid reset", req_ready, 1);
    chk(in_ready == 1'b0, "R1", "in_ready after mid reset", in_ready, 0);
    chk(cq_valid == 1'b0, "R1", "queue empty after mid reset", cq_valid, 0);
    run_req(8, 128, 2'b00, 1'b0, 2, 1'b0, 2'b00, 1'b0, 0, "after_reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule